// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block remembers the results of instructions that have already executed so that a later instance of the same instruction can commit the stored result without executing again. Entries sit in a set-associative array indexed by the instruction address. Each entry holds the instruction address as its tag, the result, the two source register names, a valid bit, a reused flag, and an optional link to the entry of the instruction that produced one of its operands. Reuse is non-speculative: a hit is reported only when the stored result is still known to be correct.

An entry stays valid until one of its source registers is written. An entry with no producer link may be reused whenever it is valid. An entry with a producer link may be reused only if the producer entry has itself been reused since it was last filled or invalidated, so reuse along a chain always proceeds from its head. The lookup port presents an address, the current source register names and an operand-ready flag, and answers one cycle later with a hit, the result and the entry identifier. The insert port records an executed result, and the register-write port invalidates entries that read the written register.

Top module: `irb_top`

## Requirements
- R1: One cycle after `lk_req`, `hit` is 1 when a valid entry tagged with `lk_pc` in set `lk_pc[4:2]` matches both register names, `lk_ready` is 1 and the chain rule holds; `hit_result` then carries the stored result and `hit_ptr` equals `{set, way}` (set in the upper bits).
- R2: With `lk_ready` low no hit is reported.
- R3: A lookup whose register names differ from the stored ones, including swapped names, reports no hit.
- R4: A register write equal to either stored source name of an entry invalidates it; later lookups miss until it is inserted again, and writes to other registers leave it usable.
- R5: An entry with a producer link hits only after its producer entry has been reused by a hit since the producer was last filled.
- R6: Invalidation of a producer clears its reused flag, so its dependent misses even though the dependent's own registers were not written.
- R7: Inserting an address that is already valid in its set overwrites that way in place; the other ways keep their contents.
- R8: An insert fills the lowest-numbered invalid way of the set; when the set is full it evicts the least recently used way, where both inserts and hits count as uses.
- R9: Filling an entry slot invalidates every entry whose producer link points to that slot.
- R10: After reset the buffer is empty and `hit` is 0.
- R11: In a cycle following no lookup request, `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_rs1 | input | REG_W | First source register name presented |
| lk_rs2 | input | REG_W | Second source register name presented |
| lk_ready | input | 1 | Operands ready for the reuse test |
| ins_req | input | 1 | Insert request |
| ins_pc | input | PC_W | Address of the executed instruction |
| ins_rs1 | input | REG_W | First source register name to store |
| ins_rs2 | input | REG_W | Second source register name to store |
| ins_result | input | DATA_W | Result to store |
| ins_has_dep | input | 1 | Entry depends on a producer entry |
| ins_dep | input | ENT_W | Producer entry identifier `{set, way}` |
| wr_req | input | 1 | Register write observed |
| wr_reg | input | REG_W | Register name being written |
| hit | output | 1 | Reuse hit for the previous cycle's lookup |
| hit_result | output | DATA_W | Stored result on a hit |
| hit_ptr | output | ENT_W | Entry identifier `{set, way}` on a hit |

## Verification
The bench uses the default build of 8 sets of 4 ways, 5-bit register names and 32-bit results, with set selection from address bits 4:2. Four ways let one set be filled, refreshed by a hit and overflowed within a few dozen cycles, so the least-recent eviction order is observable at the lookup port. Eight sets let a producer and its dependent sit in different sets, which separates the chain check from the set that the lookup reads.

// File: rtl/irb_pkg.sv
package irb_pkg;
    // Source of the way chosen for an insert
    typedef enum logic [1:0] {
        PICK_SAME_PC = 2'd0,
        PICK_EMPTY   = 2'd1,
        PICK_OLDEST  = 2'd2
    } pick_e;
endpackage

// File: rtl/irb_way_cmp.sv
module irb_way_cmp #(
    parameter int PC_W  = 32,
    parameter int REG_W = 5
) (
    input  logic             e_valid,
    input  logic [PC_W-1:0]  e_tag,
    input  logic [REG_W-1:0] e_rs1,
    input  logic [REG_W-1:0] e_rs2,
    input  logic             e_has_dep,
    input  logic             prod_reused,
    input  logic [PC_W-1:0]  q_pc,
    input  logic [REG_W-1:0] q_rs1,
    input  logic [REG_W-1:0] q_rs2,
    input  logic             q_ready,
    output logic             same_pc,
    output logic             reusable
);
    always_comb begin
        same_pc  = e_valid && (e_tag == q_pc);
        reusable = same_pc && q_ready && (e_rs1 == q_rs1) && (e_rs2 == q_rs2)
                   && (!e_has_dep || prod_reused);
    end
endmodule

// File: rtl/irb_victim.sv
module irb_victim
    import irb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]            same_pc,
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic [WAY_W-1:0]           way,
    output pick_e                      pick
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    always_comb begin
        way  = '0;
        pick = PICK_OLDEST;
        for (int w = 0; w < WAYS; w++) begin
            if (age[w] == OLDEST) way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                way  = WAY_W'(w);
                pick = PICK_EMPTY;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (same_pc[w]) begin
                way  = WAY_W'(w);
                pick = PICK_SAME_PC;
            end
        end
    end
endmodule

// File: rtl/irb_top.sv
module irb_top
    import irb_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int PC_W   = 32,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int ENT_W = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [REG_W-1:0]  lk_rs1,
    input  logic [REG_W-1:0]  lk_rs2,
    input  logic              lk_ready,
    input  logic              ins_req,
    input  logic [PC_W-1:0]   ins_pc,
    input  logic [REG_W-1:0]  ins_rs1,
    input  logic [REG_W-1:0]  ins_rs2,
    input  logic [DATA_W-1:0] ins_result,
    input  logic              ins_has_dep,
    input  logic [ENT_W-1:0]  ins_dep,
    input  logic              wr_req,
    input  logic [REG_W-1:0]  wr_reg,
    output logic              hit,
    output logic [DATA_W-1:0] hit_result,
    output logic [ENT_W-1:0]  hit_ptr
);
    localparam int AGE_W   = WAY_W;
    localparam int N       = SETS * WAYS;
    localparam int IDX_LSB = 2;

    typedef struct packed {
        logic              valid;
        logic              reused;
        logic [PC_W-1:0]   tag;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic [DATA_W-1:0] res;
        logic              has_dep;
        logic [ENT_W-1:0]  dep;
    } ent_t;

    typedef logic [WAYS-1:0][AGE_W-1:0] ages_t;

    typedef struct packed {
        ent_t  [N-1:0]    ent;
        ages_t [SETS-1:0] age;
        logic              hit;
        logic [DATA_W-1:0] res;
        logic [ENT_W-1:0]  ptr;
    } state_t;

    state_t s_q, s_d;

    function automatic ages_t touch(ages_t a, logic [WAY_W-1:0] w);
        ages_t r = a;
        for (int j = 0; j < WAYS; j++) begin
            if (a[j] < a[w]) r[j] = a[j] + AGE_W'(1);
        end
        r[w] = '0;
        return r;
    endfunction

    function automatic state_t reset_state();
        state_t r = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) r.age[s][w] = AGE_W'(w);
        end
        return r;
    endfunction

    logic [SET_W-1:0] lk_set, ins_set;
    logic [WAYS-1:0]  lk_ok, ins_same, ins_valid;
    logic [WAY_W-1:0] hit_way, vic_way;
    logic [ENT_W-1:0] hit_idx, slot;
    pick_e            vic_pick;

    assign lk_set  = lk_pc[IDX_LSB +: SET_W];
    assign ins_set = ins_pc[IDX_LSB +: SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ent_t le, ie;
        logic lk_same;
        assign le = s_q.ent[{lk_set, WAY_W'(w)}];
        assign ie = s_q.ent[{ins_set, WAY_W'(w)}];
        assign ins_valid[w] = ie.valid;

        irb_way_cmp #(.PC_W(PC_W), .REG_W(REG_W)) u_lk (
            .e_valid(le.valid), .e_tag(le.tag), .e_rs1(le.rs1), .e_rs2(le.rs2),
            .e_has_dep(le.has_dep), .prod_reused(s_q.ent[le.dep].reused),
            .q_pc(lk_pc), .q_rs1(lk_rs1), .q_rs2(lk_rs2), .q_ready(lk_ready),
            .same_pc(lk_same), .reusable(lk_ok[w])
        );

        irb_way_cmp #(.PC_W(PC_W), .REG_W(REG_W)) u_ins (
            .e_valid(ie.valid), .e_tag(ie.tag), .e_rs1(ie.rs1), .e_rs2(ie.rs2),
            .e_has_dep(ie.has_dep), .prod_reused(1'b1),
            .q_pc(ins_pc), .q_rs1(ins_rs1), .q_rs2(ins_rs2), .q_ready(1'b1),
            .same_pc(ins_same[w]), .reusable()
        );
    end

    irb_victim #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_vic (
        .same_pc(ins_same), .valid(ins_valid), .age(s_q.age[ins_set]),
        .way(vic_way), .pick(vic_pick)
    );

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_ok[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit_idx = {lk_set, hit_way};
    assign slot    = {ins_set, vic_way};

    always_comb begin
        s_d     = s_q;
        s_d.hit = 1'b0;
        // lookup: judged on the state before this edge
        if (lk_req && (|lk_ok)) begin
            s_d.hit                 = 1'b1;
            s_d.res                 = s_q.ent[hit_idx].res;
            s_d.ptr                 = hit_idx;
            s_d.ent[hit_idx].reused = 1'b1;
            s_d.age[lk_set]         = touch(s_q.age[lk_set], hit_way);
        end
        // register write: clear every reader of the register
        if (wr_req) begin
            for (int i = 0; i < N; i++) begin
                if (s_q.ent[i].rs1 == wr_reg || s_q.ent[i].rs2 == wr_reg) begin
                    s_d.ent[i].valid  = 1'b0;
                    s_d.ent[i].reused = 1'b0;
                end
            end
        end
        // insert: unlink dependents of the slot, then fill it
        if (ins_req) begin
            for (int i = 0; i < N; i++) begin
                if (s_q.ent[i].has_dep && s_q.ent[i].dep == slot) begin
                    s_d.ent[i].valid  = 1'b0;
                    s_d.ent[i].reused = 1'b0;
                end
            end
            s_d.ent[slot].valid   = 1'b1;
            s_d.ent[slot].reused  = 1'b0;
            s_d.ent[slot].tag     = ins_pc;
            s_d.ent[slot].rs1     = ins_rs1;
            s_d.ent[slot].rs2     = ins_rs2;
            s_d.ent[slot].res     = ins_result;
            s_d.ent[slot].has_dep = ins_has_dep;
            s_d.ent[slot].dep     = ins_dep;
            s_d.age[ins_set]      = touch(s_d.age[ins_set], vic_way);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign hit        = s_q.hit;
    assign hit_result = s_q.res;
    assign hit_ptr    = s_q.ptr;
endmodule

// File: rtl/irb_chk.sv
module irb_chk #(
    parameter int PC_W  = 32,
    parameter int SET_W = 3,
    parameter int WAY_W = 2,
    localparam int ENT_W = SET_W + WAY_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             lk_ready,
    input logic [PC_W-1:0]  lk_pc,
    input logic             hit,
    input logic [ENT_W-1:0] hit_ptr
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !hit); // R10

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(lk_req)); // R11

    AST_HIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(lk_ready)); // R2

    AST_HIT_SET_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_ptr[ENT_W-1 -: SET_W] == $past(lk_pc[2 +: SET_W]))); // R1
endmodule

bind irb_top irb_chk #(.PC_W(PC_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ready(lk_ready),
    .lk_pc(lk_pc), .hit(hit), .hit_ptr(hit_ptr)
);

// File: tb/tb_irb_top.sv
`timescale 1ns/1ps
module tb_irb_top;
    localparam int PC_W = 32, REG_W = 5, DATA_W = 32, ENT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0, lk_ready = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic [REG_W-1:0] lk_rs1 = '0, lk_rs2 = '0;
    logic ins_req = 1'b0, ins_has_dep = 1'b0;
    logic [PC_W-1:0] ins_pc = '0;
    logic [REG_W-1:0] ins_rs1 = '0, ins_rs2 = '0;
    logic [DATA_W-1:0] ins_result = '0;
    logic [ENT_W-1:0] ins_dep = '0;
    logic wr_req = 1'b0;
    logic [REG_W-1:0] wr_reg = '0;
    logic hit;
    logic [DATA_W-1:0] hit_result;
    logic [ENT_W-1:0] hit_ptr;

    always #2 clk = ~clk;

    irb_top dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pc(lk_pc), .lk_rs1(lk_rs1),
        .lk_rs2(lk_rs2), .lk_ready(lk_ready), .ins_req(ins_req), .ins_pc(ins_pc),
        .ins_rs1(ins_rs1), .ins_rs2(ins_rs2), .ins_result(ins_result),
        .ins_has_dep(ins_has_dep), .ins_dep(ins_dep), .wr_req(wr_req), .wr_reg(wr_reg),
        .hit(hit), .hit_result(hit_result), .hit_ptr(hit_ptr)
    );

    typedef struct {
        bit                hit;
        logic [DATA_W-1:0] res;
        logic [ENT_W-1:0]  ptr;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic idle();
        lk_req = 1'b0; ins_req = 1'b0; wr_req = 1'b0;
    endtask

    task automatic lookup(input logic [PC_W-1:0] pc, input logic [REG_W-1:0] a,
                          input logic [REG_W-1:0] b, input bit rdy, input bit eh,
                          input logic [DATA_W-1:0] er, input logic [ENT_W-1:0] ep,
                          input string req);
        exp_t e;
        @(negedge clk);
        idle();
        lk_req = 1'b1; lk_pc = pc; lk_rs1 = a; lk_rs2 = b; lk_ready = rdy;
        e.hit = eh; e.res = er; e.ptr = ep; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic insert(input logic [PC_W-1:0] pc, input logic [REG_W-1:0] a,
                          input logic [REG_W-1:0] b, input logic [DATA_W-1:0] r,
                          input bit hd, input logic [ENT_W-1:0] d);
        @(negedge clk);
        idle();
        ins_req = 1'b1; ins_pc = pc; ins_rs1 = a; ins_rs2 = b; ins_result = r;
        ins_has_dep = hd; ins_dep = d;
    endtask

    task automatic regwrite(input logic [REG_W-1:0] r);
        @(negedge clk);
        idle();
        wr_req = 1'b1; wr_reg = r;
    endtask

    // monitor: compares each cycle's output against the scoreboard
    always @(posedge clk) begin
        bit sampled;
        sampled = lk_req && rst_n;
        #1;
        if (rst_n && !done) begin
            checks++;
            if (sampled) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.hit) begin
                    if (!(hit && hit_result == e.res && hit_ptr == e.ptr)) begin
                        failures++;
                        $display("FAIL %s: hit=%0b res=%h ptr=%0d expected hit=1 res=%h ptr=%0d",
                                 e.req, hit, hit_result, hit_ptr, e.res, e.ptr);
                    end
                end else if (hit) begin
                    failures++;
                    $display("FAIL %s: hit=1 expected hit=0", e.req);
                end
            end else if (hit) begin
                failures++;
                $display("FAIL R11: hit=1 expected hit=0 with no lookup");
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (hit !== 1'b0) begin
            failures++;
            $display("FAIL R10: hit=%b expected 0 in reset", hit);
        end
        @(negedge clk);
        rst_n = 1'b1;

        lookup(32'h100, 1, 2, 1, 0, 0, 0, "R10");          // empty after reset
        insert(32'h100, 1, 2, 32'hAAAA, 0, 0);             // set0 way0 -> id 0
        lookup(32'h100, 1, 2, 1, 1, 32'hAAAA, 0, "R1");
        lookup(32'h100, 1, 3, 1, 0, 0, 0, "R3");
        lookup(32'h100, 2, 1, 1, 0, 0, 0, "R3");           // swapped names
        lookup(32'h100, 1, 2, 0, 0, 0, 0, "R2");
        insert(32'h104, 3, 4, 32'hBBBB, 1, 5'd0);          // set1 way0 -> id 4
        lookup(32'h104, 3, 4, 1, 1, 32'hBBBB, 5'd4, "R5");
        regwrite(9);                                        // unrelated register
        lookup(32'h100, 1, 2, 1, 1, 32'hAAAA, 0, "R4");
        regwrite(2);
        lookup(32'h100, 1, 2, 1, 0, 0, 0, "R4");
        lookup(32'h104, 3, 4, 1, 0, 0, 0, "R6");
        insert(32'h100, 1, 2, 32'hA2, 0, 0);               // refill id 0
        lookup(32'h100, 1, 2, 1, 1, 32'hA2, 0, "R1");
        lookup(32'h104, 3, 4, 1, 0, 0, 0, "R9");
        insert(32'h120, 6, 7, 32'hC0C0, 0, 0);             // set0 way1
        insert(32'h100, 1, 2, 32'hA3, 0, 0);               // overwrite in place
        lookup(32'h100, 1, 2, 1, 1, 32'hA3, 0, "R7");
        lookup(32'h120, 6, 7, 1, 1, 32'hC0C0, 1, "R7");
        insert(32'h140, 6, 7, 32'hD0D0, 0, 0);             // way2
        insert(32'h160, 6, 7, 32'hE0E0, 0, 0);             // way3
        lookup(32'h160, 6, 7, 1, 1, 32'hE0E0, 3, "R8");
        lookup(32'h100, 1, 2, 1, 1, 32'hA3, 0, "R8");      // refresh way0
        insert(32'h180, 6, 7, 32'hF0F0, 0, 0);             // evicts way1
        lookup(32'h120, 6, 7, 1, 0, 0, 0, "R8");
        lookup(32'h180, 6, 7, 1, 1, 32'hF0F0, 1, "R8");
        lookup(32'h140, 6, 7, 1, 1, 32'hD0D0, 2, "R8");
        lookup(32'h100, 1, 2, 1, 1, 32'hA3, 0, "R8");
        insert(32'h108, 10, 11, 32'h6666, 0, 0);           // set2 way0 -> id 8
        insert(32'h10C, 12, 13, 32'h7777, 1, 5'd8);        // set3 way0 -> id 12
        lookup(32'h10C, 12, 13, 1, 0, 0, 0, "R5");
        lookup(32'h108, 10, 11, 1, 1, 32'h6666, 5'd8, "R5");
        lookup(32'h10C, 12, 13, 1, 1, 32'h7777, 5'd12, "R5");
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1: %0d lookups unanswered expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule